// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the timing strobes of an 8-bit microcontroller's external memory bus. A machine cycle lasts twelve oscillator periods. A phase counter supplied from outside steps through them, and the block turns it into two pulses:

- the address-latch pulse, which external logic uses to capture the low address byte;
- the active-low program-read strobe, which fetches code from external memory.

During an external data transfer, the block drops the address-latch and program-read pulses that would collide with the transfer. In their place it raises a data read/write strobe. It also tells the port-2 pad logic whether to drive the upper address byte or the port's own register.

The surrounding core supplies per-cycle flags that stay constant for the whole machine cycle: external code fetch, external data access, pointer width, code-table read, the address-latch disable bit and the external-execution indication. All outputs are registered and follow the phase input by one clock.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n` is 1, `xmem_stb` is 0 and `p2_hi_addr` is 0.
- R2: Each output is registered: it reflects the phase and flags applied in the previous clock. `cyc_phase` counts 0 to 11 within a machine cycle. With no data access and the disable bit clear, `ale` is 1 for phases 0, 1, 6 and 7 and 0 otherwise, which is two pulses per machine cycle.
- R3: In a machine cycle with `xdata_acc` high, the `ale` pulse at phases 0 and 1 is omitted; the pulse at phases 6 and 7 remains.
- R4: With `code_fetch_ext` high and `xdata_acc` low, `psen_n` is 0 for phases 3, 4, 9 and 10 and 1 otherwise. With `code_fetch_ext` low, `psen_n` stays 1.
- R5: In a machine cycle with `xdata_acc` high, both `psen_n` pulses are omitted, even if `code_fetch_ext` is high.
- R6: `xmem_stb` is 1 for phases 2 through 9 of a machine cycle with `xdata_acc` high. It is 0 at all other times.
- R7: With `ale_off` high, `ext_exec` low and neither `xdata_acc` nor `movc_acc` high, `ale` is held at constant 1, which models the weak pull-up.
- R8: With `ale_off` high, a cycle with `movc_acc` or `xdata_acc` high still produces the normal `ale` waveform of R2 and R3.
- R9: With `ext_exec` high, `ale_off` has no effect and `ale` follows R2 and R3.
- R10: `p2_hi_addr` is 1 (upper address byte) when `xdata_acc` and `xdata_wide` are both high. It is 0 (port register) when `xdata_acc` is high and `xdata_wide` is low. Outside data cycles it equals `code_fetch_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_phase | input | 4 | Oscillator phase within the machine cycle, 0 to 11 |
| code_fetch_ext | input | 1 | Code is fetched from external memory in this cycle |
| xdata_acc | input | 1 | External data transfer cycle |
| xdata_wide | input | 1 | Data transfer uses a 16-bit pointer |
| movc_acc | input | 1 | Code-table read cycle |
| ale_off | input | 1 | Address-latch disable bit |
| ext_exec | input | 1 | Device executes from external program memory |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| xmem_stb | output | 1 | Data read/write strobe, active high |
| p2_hi_addr | output | 1 | Port 2 drives the upper address byte when 1 |

## Verification
The checker watches every cycle for the following:
- the program-read strobe firing in a data cycle;
- the data and program strobes overlapping;
- a missing pull-up level while the latch pulse is disabled;
- the first latch pulse appearing in a data cycle;
- the wrong port-2 source for 8-bit pointers.

Only the bench scenarios can show the exact phase positions and widths of each pulse. The same holds for the override by external execution, the re-enabling of the latch pulse in code-table cycles, and the reset levels. The bench compares every output on every phase against a per-phase expectation.

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen #(
  parameter int PH_W = 4,
  parameter int PH_N = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] cyc_phase,
  input  logic            code_fetch_ext,
  input  logic            xdata_acc,
  input  logic            xdata_wide,
  input  logic            movc_acc,
  input  logic            ale_off,
  input  logic            ext_exec,
  output logic            ale,
  output logic            psen_n,
  output logic            xmem_stb,
  output logic            p2_hi_addr
);
  localparam int HALF   = PH_N / 2;
  localparam int PS_OFF = HALF / 2;
  localparam int STB_LO = 2;
  localparam int STB_HI = PH_N - 3;

  function automatic logic in_win(input logic [PH_W-1:0] ph, input int start);
    return (int'(ph) >= start) && (int'(ph) < start + 2);
  endfunction

  logic ale_pulse, ale_gate, ale_d, psen_d, stb_d, p2_d;

  assign ale_pulse = (in_win(cyc_phase, 0) && !xdata_acc) || in_win(cyc_phase, HALF);
  assign ale_gate  = !ale_off || ext_exec || xdata_acc || movc_acc;
  assign ale_d     = ale_gate ? ale_pulse : 1'b1;
  assign psen_d    = !(code_fetch_ext && !xdata_acc &&
                       (in_win(cyc_phase, PS_OFF) || in_win(cyc_phase, HALF + PS_OFF)));
  assign stb_d     = xdata_acc && (int'(cyc_phase) >= STB_LO) && (int'(cyc_phase) <= STB_HI);
  assign p2_d      = xdata_acc ? xdata_wide : code_fetch_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale        <= 1'b0;
      psen_n     <= 1'b1;
      xmem_stb   <= 1'b0;
      p2_hi_addr <= 1'b0;
    end else begin
      ale        <= ale_d;
      psen_n     <= psen_d;
      xmem_stb   <= stb_d;
      p2_hi_addr <= p2_d;
    end
  end
endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk #(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PH_W-1:0] cyc_phase,
  input logic            code_fetch_ext,
  input logic            xdata_acc,
  input logic            xdata_wide,
  input logic            movc_acc,
  input logic            ale_off,
  input logic            ext_exec,
  input logic            ale,
  input logic            psen_n,
  input logic            xmem_stb,
  input logic            p2_hi_addr
);
  logic ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ok <= 1'b0;
    else        ok <= 1'b1;

  assert_no_psen_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(xdata_acc)) |-> psen_n);

  assert_no_strobe_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(xmem_stb && !psen_n));

  assert_stb_only_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && xmem_stb) |-> $past(xdata_acc));

  assert_ale_pulled_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(ale_off && !ext_exec && !xdata_acc && !movc_acc)) |-> ale);

  assert_first_ale_skipped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(xdata_acc && cyc_phase == '0)) |-> !ale);

  assert_narrow_ptr_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(xdata_acc && !xdata_wide)) |-> !p2_hi_addr);
endmodule

bind ext_bus_strobe_gen ext_bus_strobe_chk #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_phase(cyc_phase), .code_fetch_ext(code_fetch_ext),
  .xdata_acc(xdata_acc), .xdata_wide(xdata_wide), .movc_acc(movc_acc),
  .ale_off(ale_off), .ext_exec(ext_exec), .ale(ale), .psen_n(psen_n),
  .xmem_stb(xmem_stb), .p2_hi_addr(p2_hi_addr));

// File: tb/ext_bus_strobe_gen_tb.sv
module ext_bus_strobe_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cyc_phase = '0;
  logic code_fetch_ext = 0, xdata_acc = 0, xdata_wide = 0, movc_acc = 0, ale_off = 0, ext_exec = 0;
  logic ale, psen_n, xmem_stb, p2_hi_addr;

  always #5 clk = ~clk;

  ext_bus_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_phase(cyc_phase), .code_fetch_ext(code_fetch_ext),
    .xdata_acc(xdata_acc), .xdata_wide(xdata_wide), .movc_acc(movc_acc),
    .ale_off(ale_off), .ext_exec(ext_exec), .ale(ale), .psen_n(psen_n),
    .xmem_stb(xmem_stb), .p2_hi_addr(p2_hi_addr));

  typedef struct { logic [3:0] v; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [3:0] model(int ph, logic cf, logic xd, logic xw, logic mv, logic off, logic ex);
    logic a, p, s, h;
    if (off && !ex && !xd && !mv) a = 1'b1;
    else a = ((ph == 0 || ph == 1) && !xd) || ph == 6 || ph == 7;
    p = !(cf && !xd && (ph == 3 || ph == 4 || ph == 9 || ph == 10));
    s = xd && ph >= 2 && ph <= 9;
    h = xd ? xw : cf;
    return {a, p, s, h};
  endfunction

  task automatic run_cycle(string tag, logic cf, logic xd, logic xw, logic mv, logic off, logic ex);
    for (int ph = 0; ph < 12; ph++) begin
      @(negedge clk);
      cyc_phase = 4'(ph); code_fetch_ext = cf; xdata_acc = xd; xdata_wide = xw;
      movc_acc = mv; ale_off = off; ext_exec = ex;
      q.push_back('{model(ph, cf, xd, xw, mv, off, ex), tag});
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({ale, psen_n, xmem_stb, p2_hi_addr} !== e.v) begin
          fails++;
          $display("FAIL %s: {ale,psen_n,stb,p2}=%b expected %b", e.tag,
                   {ale, psen_n, xmem_stb, p2_hi_addr}, e.v);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          fails++; checks++;
          $display("FAIL watchdog: run incomplete, expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    // R1 reset levels
    if ({ale, psen_n, xmem_stb, p2_hi_addr} !== 4'b0100) begin
      fails++;
      $display("FAIL R1: %b expected 0100", {ale, psen_n, xmem_stb, p2_hi_addr});
    end
    @(negedge clk); rst_n = 1'b1;
    run_cycle("R2", 0, 0, 0, 0, 0, 0);
    run_cycle("R4", 1, 0, 0, 0, 0, 0);
    run_cycle("R4", 1, 0, 0, 0, 0, 1);
    run_cycle("R3", 0, 1, 1, 0, 0, 0);
    run_cycle("R5", 1, 1, 1, 0, 0, 1);
    run_cycle("R6", 0, 1, 0, 0, 0, 0);
    run_cycle("R10", 1, 1, 0, 0, 0, 1);
    run_cycle("R10", 0, 1, 1, 0, 0, 0);
    run_cycle("R7", 0, 0, 0, 0, 1, 0);
    run_cycle("R8", 0, 0, 0, 1, 1, 0);
    run_cycle("R8", 0, 1, 1, 0, 1, 0);
    run_cycle("R9", 1, 0, 0, 0, 1, 1);
    run_cycle("R7", 1, 0, 0, 0, 1, 0);
    run_cycle("R2", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    code_fetch_ext = 0; xdata_acc = 0; ale_off = 0; movc_acc = 0; ext_exec = 0;
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule